// File: doc/BRIEF.md
# Trap Entry and Status Merge Unit

This block owns the processor's three-bit mode status: user mode, traps enabled, and a reschedule flag. It performs trap entry. For a requested trap code it forms the vector address, hands the pre-trap status word to the data stack, and drops the core into kernel mode with traps disabled. The cycle in which the vector appears also carries an abort strobe, so the faulting instruction leaves no other trace.

It also merges a status operand taken from the stack. Each field in the operand has its own keep bit, so software can change one mode bit without touching the others. A status write issued while in user mode is illegal and becomes a mode-fault trap. A predicted control-stack overflow replaces the requested trap code whenever traps are enabled. I/O stores carrying two special codes are decoded here: one raises the reschedule flag and the other raises a one-cycle reset request.

Top module: `kstat_trap_ctl`

## Requirements
- R1: After reset, `stat_user`, `stat_ten`, `stat_resched`, `abort`, `push_vld`, `reset_req` are all 0 and `trap_pc` is 0.
- R2: One cycle after a cycle with `trap_req` high, `abort` and `push_vld` are 1, and `stat_user` and `stat_ten` are 0. `stat_resched` keeps its value. Both strobes return to 0 in the following cycle when no trap is taken.
- R3: On trap entry, `push_word` carries the status held before the trap: user at bit 0, traps-enabled at bit 2, reschedule at bit 4, and every other bit 0.
- R4: On trap entry, `trap_pc` equals `TRAP_BASE + (code << VEC_SHIFT)`. It is registered in the same cycle as `abort`. With the defaults this is 0x2000 + code*16.
- R5: When traps are enabled and `ctl_ovf_pending` is high, the code used is `OVF_CODE` (default 4, PC 0x2040) instead of the requested one. When traps are disabled, `ctl_ovf_pending` has no effect on the code.
- R6: A status write copies each field from `swr_word` only when that field's keep bit is 0. The operand layout is: user value at bit 0, user keep at bit 1, traps-enabled value at bit 2, traps-enabled keep at bit 3, reschedule value at bit 4, reschedule keep at bit 5.
- R7: A status write requested while `stat_user` is 1 does not merge. It enters a trap with `MODE_CODE` (default 5, PC 0x2050).
- R8: A trap and a status write in the same cycle take the trap. The write operand is discarded.
- R9: An I/O store of `RESCHED_CODE` (default 1) sets `stat_resched` one cycle later. This takes priority over a same-cycle status write that clears it.
- R10: An I/O store of `RESET_CODE` (default 2) makes `reset_req` 1 for exactly one cycle. Other I/O values leave `reset_req` and the status unchanged.
- R11: With no trap, status write or I/O store, the status holds and `abort` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap request this cycle |
| trap_code | input | CODE_W | Requested trap index |
| ctl_ovf_pending | input | 1 | Control stack would overflow on a push |
| swr_req | input | 1 | Status write request |
| swr_word | input | WORD_W | Status operand with per-field keep bits |
| io_wr_vld | input | 1 | I/O store valid |
| io_wr_data | input | WORD_W | I/O store data word |
| stat_user | output | 1 | User mode bit |
| stat_ten | output | 1 | Traps enabled bit |
| stat_resched | output | 1 | Reschedule bit |
| abort | output | 1 | Abort strobe for the trapped instruction |
| push_vld | output | 1 | Request to push `push_word` onto the data stack |
| push_word | output | WORD_W | Pre-trap status word |
| trap_pc | output | PC_W | Trap vector address |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The bench targets the places where priorities meet.

- **Overflow override.** It is tried with traps disabled and with traps enabled. A design that ignores the enable would send a kernel with traps off to the overflow vector.
- **Keep bits.** Mixed keep patterns are applied. A design that decodes the layout wrongly, or ignores one keep bit, would change a field that was meant to hold.
- **Trap versus status write.** A trap is raised together with a status write that tries to set reschedule. A design that lets the write through would set the bit.
- **Pushed word.** The pushed word is compared against the pre-trap status. A design that pushes the post-trap value would show zeros.
- **User-mode write.** A status write in user mode must vector to the mode-fault address rather than merge.
- **Reschedule priority.** A reschedule store is issued in the same cycle as a clearing status write, and the reschedule must win.

// File: rtl/kstat_pkg.sv
package kstat_pkg;
   // status held as a vector: index 0 user, 1 traps enabled, 2 reschedule
   localparam int unsigned NFIELD     = 3;
   localparam int unsigned FIELD_SPAN = 2 * NFIELD;

   typedef struct packed {
      logic resched;
      logic ten;
      logic user;
   } kstat_t;

   function automatic logic [FIELD_SPAN-1:0] kstat_to_word(input kstat_t s);
      return {1'b0, s.resched, 1'b0, s.ten, 1'b0, s.user};
   endfunction
endpackage

// File: rtl/kstat_merge.sv
module kstat_merge
   import kstat_pkg::*;
(
   input  kstat_t                cur,
   input  logic [FIELD_SPAN-1:0] opnd,
   output kstat_t                merged
);
   logic [NFIELD-1:0] cur_v;
   logic [NFIELD-1:0] mrg_v;

   assign cur_v = {cur.resched, cur.ten, cur.user};

   for (genvar i = 0; i < NFIELD; i++) begin : g_field
      // odd bit is the keep flag for the even value bit below it
      assign mrg_v[i] = opnd[2*i+1] ? cur_v[i] : opnd[2*i];
   end

   assign merged = '{resched: mrg_v[2], ten: mrg_v[1], user: mrg_v[0]};
endmodule

// File: rtl/kstat_vec_gen.sv
module kstat_vec_gen #(
   parameter int unsigned           CODE_W    = 8,
   parameter int unsigned           PC_W      = 32,
   parameter int unsigned           VEC_SHIFT = 4,
   parameter bit                    JOIN_OR   = 1'b0,
   parameter logic [PC_W-1:0]       TRAP_BASE = 'h2000,
   parameter logic [CODE_W-1:0]     OVF_CODE  = 'h04
) (
   input  logic [CODE_W-1:0] req_code,
   input  logic              ovf_hit,
   output logic [CODE_W-1:0] eff_code,
   output logic [PC_W-1:0]   vec_pc
);
   localparam int unsigned PAD_W = PC_W - CODE_W;

   logic [PC_W-1:0] code_ext;
   logic [PC_W-1:0] code_sh;

   assign eff_code = ovf_hit ? OVF_CODE : req_code;
   assign code_ext = {{PAD_W{1'b0}}, eff_code};
   assign code_sh  = code_ext << VEC_SHIFT;

   if (JOIN_OR) begin : g_or
      assign vec_pc = TRAP_BASE | code_sh;
   end else begin : g_add
      assign vec_pc = TRAP_BASE + code_sh;
   end
endmodule

// File: rtl/kstat_io_dec.sv
module kstat_io_dec #(
   parameter int unsigned       WORD_W       = 32,
   parameter logic [WORD_W-1:0] RESCHED_CODE = 'h1,
   parameter logic [WORD_W-1:0] RESET_CODE   = 'h2
) (
   input  logic              io_wr_vld,
   input  logic [WORD_W-1:0] io_wr_data,
   output logic              hit_resched,
   output logic              hit_reset
);
   assign hit_resched = io_wr_vld && (io_wr_data == RESCHED_CODE);
   assign hit_reset   = io_wr_vld && (io_wr_data == RESET_CODE);
endmodule

// File: rtl/kstat_trap_ctl.sv
module kstat_trap_ctl
   import kstat_pkg::*;
#(
   parameter int unsigned       WORD_W       = 32,
   parameter int unsigned       CODE_W       = 8,
   parameter int unsigned       PC_W         = 32,
   parameter int unsigned       VEC_SHIFT    = 4,
   parameter bit                JOIN_OR      = 1'b0,
   parameter logic [PC_W-1:0]   TRAP_BASE    = 'h2000,
   parameter logic [CODE_W-1:0] OVF_CODE     = 'h04,
   parameter logic [CODE_W-1:0] MODE_CODE    = 'h05,
   parameter logic [WORD_W-1:0] RESCHED_CODE = 'h1,
   parameter logic [WORD_W-1:0] RESET_CODE   = 'h2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_req,
   input  logic [CODE_W-1:0] trap_code,
   input  logic              ctl_ovf_pending,
   input  logic              swr_req,
   input  logic [WORD_W-1:0] swr_word,
   input  logic              io_wr_vld,
   input  logic [WORD_W-1:0] io_wr_data,
   output logic              stat_user,
   output logic              stat_ten,
   output logic              stat_resched,
   output logic              abort,
   output logic              push_vld,
   output logic [WORD_W-1:0] push_word,
   output logic [PC_W-1:0]   trap_pc,
   output logic              reset_req
);
   localparam int unsigned   HI_W     = WORD_W - FIELD_SPAN;
   localparam int unsigned   VEC_TOP  = CODE_W + VEC_SHIFT;
   localparam logic [PC_W-1:0] LOW_MASK = (PC_W'(1) << VEC_TOP) - PC_W'(1);

   // elaboration-time parameter checks
   if (WORD_W <= FIELD_SPAN) begin : g_bad_word
      $error("WORD_W must exceed the status field span");
   end
   if (PC_W <= VEC_TOP) begin : g_bad_pc
      $error("PC_W must exceed CODE_W + VEC_SHIFT");
   end
   if (JOIN_OR && ((TRAP_BASE & LOW_MASK) != '0)) begin : g_bad_base
      $error("OR join needs TRAP_BASE aligned above the shifted code");
   end
   if (OVF_CODE == MODE_CODE) begin : g_bad_codes
      $error("overflow and mode-fault codes must differ");
   end

   kstat_t              stat_q, stat_d, merged;
   logic                hit_resched, hit_reset;
   logic                mode_fault, take_trap, ovf_hit;
   logic [CODE_W-1:0]   raw_code, eff_code;
   logic [PC_W-1:0]     vec_pc;
   logic [HI_W-1:0]     unused_swr_hi;

   assign unused_swr_hi = swr_word[WORD_W-1:FIELD_SPAN];

   kstat_merge u_merge (
      .cur    (stat_q),
      .opnd   (swr_word[FIELD_SPAN-1:0]),
      .merged (merged)
   );

   kstat_vec_gen #(
      .CODE_W    (CODE_W),
      .PC_W      (PC_W),
      .VEC_SHIFT (VEC_SHIFT),
      .JOIN_OR   (JOIN_OR),
      .TRAP_BASE (TRAP_BASE),
      .OVF_CODE  (OVF_CODE)
   ) u_vec (
      .req_code (raw_code),
      .ovf_hit  (ovf_hit),
      .eff_code (eff_code),
      .vec_pc   (vec_pc)
   );

   kstat_io_dec #(
      .WORD_W       (WORD_W),
      .RESCHED_CODE (RESCHED_CODE),
      .RESET_CODE   (RESET_CODE)
   ) u_io (
      .io_wr_vld   (io_wr_vld),
      .io_wr_data  (io_wr_data),
      .hit_resched (hit_resched),
      .hit_reset   (hit_reset)
   );

   always_comb begin
      mode_fault = swr_req && stat_q.user && !trap_req;
      take_trap  = trap_req || mode_fault;
      raw_code   = trap_req ? trap_code : MODE_CODE;
      ovf_hit    = stat_q.ten && ctl_ovf_pending;

      stat_d = stat_q;
      if (take_trap) begin
         stat_d.user = 1'b0;
         stat_d.ten  = 1'b0;
      end else if (swr_req) begin
         stat_d = merged;
      end
      if (hit_resched) begin
         stat_d.resched = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q    <= '0;
         abort     <= 1'b0;
         push_vld  <= 1'b0;
         push_word <= '0;
         trap_pc   <= '0;
         reset_req <= 1'b0;
      end else begin
         stat_q    <= stat_d;
         abort     <= take_trap;
         push_vld  <= take_trap;
         reset_req <= hit_reset;
         if (take_trap) begin
            push_word <= {{HI_W{1'b0}}, kstat_to_word(stat_q)};
            trap_pc   <= vec_pc;
         end
      end
   end

   // eff_code is folded into vec_pc; kept visible for debug probes
   logic [CODE_W-1:0] unused_eff_code;
   assign unused_eff_code = eff_code;

   assign stat_user    = stat_q.user;
   assign stat_ten     = stat_q.ten;
   assign stat_resched = stat_q.resched;
endmodule

// File: rtl/kstat_trap_ctl_chk.sv
module kstat_trap_ctl_chk #(
   parameter int unsigned       WORD_W       = 32,
   parameter int unsigned       CODE_W       = 8,
   parameter int unsigned       PC_W         = 32,
   parameter int unsigned       VEC_SHIFT    = 4,
   parameter logic [PC_W-1:0]   TRAP_BASE    = 'h2000,
   parameter logic [CODE_W-1:0] OVF_CODE     = 'h04,
   parameter logic [CODE_W-1:0] MODE_CODE    = 'h05,
   parameter logic [WORD_W-1:0] RESCHED_CODE = 'h1,
   parameter logic [WORD_W-1:0] RESET_CODE   = 'h2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trap_req,
   input logic [CODE_W-1:0] trap_code,
   input logic              ctl_ovf_pending,
   input logic              swr_req,
   input logic [WORD_W-1:0] swr_word,
   input logic              io_wr_vld,
   input logic [WORD_W-1:0] io_wr_data,
   input logic              stat_user,
   input logic              stat_ten,
   input logic              stat_resched,
   input logic              abort,
   input logic              push_vld,
   input logic [WORD_W-1:0] push_word,
   input logic [PC_W-1:0]   trap_pc,
   input logic              reset_req
);
   localparam logic [PC_W-1:0] OVF_PC  = TRAP_BASE + (PC_W'(OVF_CODE) << VEC_SHIFT);
   localparam logic [PC_W-1:0] MODE_PC = TRAP_BASE + (PC_W'(MODE_CODE) << VEC_SHIFT);

   logic [WORD_W-1:0] sts_word;
   assign sts_word = {{(WORD_W-5){1'b0}}, stat_resched, 1'b0, stat_ten, 1'b0, stat_user};

   p_trap_kernel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> abort && push_vld && !stat_user && !stat_ten);

   p_push_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> push_word == $past(sts_word));

   p_vec_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && !(stat_ten && ctl_ovf_pending) |=>
         trap_pc == TRAP_BASE + (PC_W'($past(trap_code)) << VEC_SHIFT));

   p_ovf_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && stat_ten && ctl_ovf_pending |=> trap_pc == OVF_PC);

   p_keep_ten_r6: assert property (@(posedge clk) disable iff (!rst_n)
      swr_req && !trap_req && !stat_user && swr_word[3] |=> $stable(stat_ten));

   p_mode_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
      swr_req && stat_user && !trap_req && !(stat_ten && ctl_ovf_pending)
         |=> abort && trap_pc == MODE_PC);

   p_resched_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr_vld && io_wr_data == RESCHED_CODE |=> stat_resched);

   p_reset_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr_vld && io_wr_data == RESET_CODE |=> reset_req);

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req && !swr_req && !io_wr_vld |=>
         !abort && $stable(stat_user) && $stable(stat_ten) && $stable(stat_resched));
endmodule

bind kstat_trap_ctl kstat_trap_ctl_chk #(
   .WORD_W       (WORD_W),
   .CODE_W       (CODE_W),
   .PC_W         (PC_W),
   .VEC_SHIFT    (VEC_SHIFT),
   .TRAP_BASE    (TRAP_BASE),
   .OVF_CODE     (OVF_CODE),
   .MODE_CODE    (MODE_CODE),
   .RESCHED_CODE (RESCHED_CODE),
   .RESET_CODE   (RESET_CODE)
) u_chk (.*);

// File: tb/kstat_trap_ctl_tb_top.sv
module kstat_trap_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        trap_req, ctl_ovf_pending, swr_req, io_wr_vld;
   logic [7:0]  trap_code;
   logic [31:0] swr_word, io_wr_data;
   logic        stat_user, stat_ten, stat_resched, abort, push_vld, reset_req;
   logic [31:0] push_word, trap_pc;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   kstat_trap_ctl dut_i (
      .clk(clk), .rst_n(rst_n),
      .trap_req(trap_req), .trap_code(trap_code), .ctl_ovf_pending(ctl_ovf_pending),
      .swr_req(swr_req), .swr_word(swr_word),
      .io_wr_vld(io_wr_vld), .io_wr_data(io_wr_data),
      .stat_user(stat_user), .stat_ten(stat_ten), .stat_resched(stat_resched),
      .abort(abort), .push_vld(push_vld), .push_word(push_word),
      .trap_pc(trap_pc), .reset_req(reset_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] sts();
      return {29'd0, stat_resched, stat_ten, stat_user};
   endfunction

   task automatic quiet();
      trap_req = 0; trap_code = '0; ctl_ovf_pending = 0;
      swr_req = 0; swr_word = '0; io_wr_vld = 0; io_wr_data = '0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 status", sts(), 32'h0);
      chk("R1 abort", {31'd0, abort}, 32'd0);
      chk("R1 push_vld", {31'd0, push_vld}, 32'd0);
      chk("R1 reset_req", {31'd0, reset_req}, 32'd0);
      chk("R1 trap_pc", trap_pc, 32'h0);
   endtask

   task automatic t_merge();
      swr_req = 1; swr_word = 32'h14; tick(); quiet();
      chk("R6 write ten+resched", sts(), 32'h6);
      swr_req = 1; swr_word = 32'h2A; tick(); quiet();
      chk("R6 all keep", sts(), 32'h6);
      swr_req = 1; swr_word = 32'h08; tick(); quiet();
      chk("R6 keep ten only", sts(), 32'h2);
   endtask

   task automatic t_trap_basic();
      trap_req = 1; trap_code = 8'h11; tick(); quiet();
      chk("R2 abort", {31'd0, abort}, 32'd1);
      chk("R2 push_vld", {31'd0, push_vld}, 32'd1);
      chk("R2 kernel traps off", sts(), 32'h0);
      chk("R3 pushed word", push_word, 32'h04);
      chk("R4 trap pc", trap_pc, 32'h2110);
      tick();
      chk("R2 abort one cycle", {31'd0, abort}, 32'd0);
      chk("R11 idle status", sts(), 32'h0);
   endtask

   task automatic t_ovf();
      trap_req = 1; trap_code = 8'h11; ctl_ovf_pending = 1; tick(); quiet();
      chk("R5 ovf ignored with traps off", trap_pc, 32'h2110);
      swr_req = 1; swr_word = 32'h04; tick(); quiet();
      trap_req = 1; trap_code = 8'h11; ctl_ovf_pending = 1; tick(); quiet();
      chk("R5 ovf override", trap_pc, 32'h2040);
      chk("R3 pushed ten", push_word, 32'h04);
   endtask

   task automatic t_user_fault();
      swr_req = 1; swr_word = 32'h05; tick(); quiet();
      chk("R6 enter user", sts(), 32'h3);
      swr_req = 1; swr_word = 32'h10; tick(); quiet();
      chk("R7 fault abort", {31'd0, abort}, 32'd1);
      chk("R7 fault pc", trap_pc, 32'h2050);
      chk("R7 write dropped", sts(), 32'h0);
      chk("R3 pushed user status", push_word, 32'h05);
   endtask

   task automatic t_collide();
      trap_req = 1; trap_code = 8'h02; swr_req = 1; swr_word = 32'h15; tick(); quiet();
      chk("R8 trap wins abort", {31'd0, abort}, 32'd1);
      chk("R8 trap wins pc", trap_pc, 32'h2020);
      chk("R8 write discarded", sts(), 32'h0);
   endtask

   task automatic t_io();
      io_wr_vld = 1; io_wr_data = 32'h1; tick(); quiet();
      chk("R9 resched set", sts(), 32'h4);
      swr_req = 1; swr_word = 32'h00; tick(); quiet();
      chk("R6 resched cleared", sts(), 32'h0);
      swr_req = 1; swr_word = 32'h00; io_wr_vld = 1; io_wr_data = 32'h1; tick(); quiet();
      chk("R9 io beats clear", sts(), 32'h4);
      io_wr_vld = 1; io_wr_data = 32'h2; tick(); quiet();
      chk("R10 reset pulse", {31'd0, reset_req}, 32'd1);
      tick();
      chk("R10 reset one cycle", {31'd0, reset_req}, 32'd0);
      io_wr_vld = 1; io_wr_data = 32'h7; tick(); quiet();
      chk("R10 other code reset", {31'd0, reset_req}, 32'd0);
      chk("R10 other code status", sts(), 32'h4);
   endtask

   task automatic t_idle();
      for (int i = 0; i < 4; i++) tick();
      chk("R11 hold status", sts(), 32'h4);
      chk("R11 no abort", {31'd0, abort}, 32'd0);
   endtask

   initial begin
      quiet();
      rst_n = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      t_reset();
      t_merge();
      t_trap_basic();
      t_ovf();
      t_user_fault();
      t_collide();
      t_io();
      t_idle();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule